// File: doc/BRIEF.md
# Reloadable Interval Timer With Access-Acknowledged Interrupt

This block is a down-counting interval timer that sits on a small register bus. Software programs a reload value, and that write also starts the count from it. On every pulse of a prescaled tick input, the count drops by a fixed step of two. It only counts while the reload value is positive, the count is positive and the timer gate bit of a separate enable-mask register is set.

When a step takes the count to zero or below, the interrupt output goes high and stays high. The count then stays where it is. Software services the timer through a status register. Any access to it, read or write, drops the interrupt and restarts the count from the reload value. A status read returns the count as it stood before the restart. A status write puts its data into the count, and the restart that follows in the same cycle replaces it, so the written value never shows.

The bus has one register per word address. A read strobe gives registered read data on the next cycle.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset, the interrupt is low, the read data is 0, and the reload, mask and count registers all read 0.
- R2: A write to the reload register (address 0) stores the value and loads the count with it in the same clock edge. A later read of address 0 returns the stored value.
- R3: On a cycle with a tick, the count drops by exactly 2 when all three conditions hold: the signed reload is greater than 0, the signed count is greater than 0, and bit 1 of the mask is set.
- R4: The count does not change on a tick when mask bit 1 is clear, whatever the other mask bits hold. It also does not change when the signed reload is 0 or negative.
- R5: The interrupt rises on the edge where a step leaves the count at 0 or below, including an odd start that ends at -1. It then stays high, and further ticks leave the count unchanged.
- R6: A read of the status register (address 1) returns the signed count held before the access. The interrupt is low from the next cycle, and the count equals the reload value.
- R7: A write to the status register drops the interrupt. The count ends equal to the reload value, not the written data.
- R8: The enable-mask register (address 2) is 32 bits wide, read/write, and reads back exactly what was written.
- R9: A status access in the same cycle as a tick takes priority: the tick is lost, the count equals the reload value and the interrupt stays low.
- R10: Read data appears on the cycle after the read strobe and holds until the next read. Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after rd_en_i |
| tick_i | input | 1 | Prescaled count pulse, one cycle wide |
| irq_o | output | 1 | Level interrupt, high until the status register is accessed |

## Verification
The checker assumes that the read and write strobes are never high in the same cycle. Its step and hold properties depend on that assumption, because a simultaneous read and write would make the access order ambiguous. The stimulus drives every bus access as a single-strobe cycle from one task per operation, and it drives the tick through its own task. The one deliberate overlap is a tick together with a status read, which checks the priority rule without breaking the strobe assumption.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Word-address register selection; the order is the bus decode.
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // One decoded bus operation for the current cycle.
    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    // True when an operation touches the status register.
    function automatic logic is_status_access(bus_op_t op);
        return (op.wr || op.rd) && (op.sel == SEL_STATUS);
    endfunction

    // True when an operation writes the given register.
    function automatic logic is_write_to(bus_op_t op, reg_sel_e s);
        return op.wr && (op.sel == s);
    endfunction

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
    import itmr_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output bus_op_t           op_o
);

    logic hi_bits;

    generate
        if (ADDR_W > 2) begin : g_wide
            assign hi_bits = |addr_i[ADDR_W-1:2];
        end else begin : g_narrow
            assign hi_bits = 1'b0;
        end
    endgenerate

    always_comb begin
        op_o.wr  = wr_en_i;
        op_o.rd  = rd_en_i;
        op_o.sel = hi_bits ? SEL_NONE : reg_sel_e'(addr_i[1:0]);
    end

endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_op_t           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] mask_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reload_o <= '0;
            mask_o   <= '0;
        end else begin
            if (is_write_to(op_i, SEL_RELOAD)) reload_o <= wdata_i;
            if (is_write_to(op_i, SEL_MASK))   mask_o   <= wdata_i;
        end
    end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP   = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_op_t           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              gate_i,
    input  logic              tick_i,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);

    localparam logic signed [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic signed [DATA_W-1:0] cnt_s;
    logic signed [DATA_W-1:0] rld_s;
    logic signed [DATA_W-1:0] stepped;
    logic                     run;

    assign cnt_s   = $signed(count_o);
    assign rld_s   = $signed(reload_i);
    assign stepped = cnt_s - STEP_V;
    assign run     = tick_i && gate_i && (rld_s > 0) && (cnt_s > 0);

    // Priority: reload write, then status access (ack + restart), then tick.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_o <= '0;
            irq_o   <= 1'b0;
        end else if (is_write_to(op_i, SEL_RELOAD)) begin
            count_o <= wdata_i;
        end else if (is_status_access(op_i)) begin
            // A status write lands in the count and is overtaken by the restart.
            count_o <= reload_i;
            irq_o   <= 1'b0;
        end else if (run) begin
            count_o <= stepped;
            if (stepped <= 0) irq_o <= 1'b1;
        end
    end

endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
    import itmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_op_t           op_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] sel_val;

    always_comb begin
        unique case (op_i.sel)
            SEL_RELOAD: sel_val = reload_i;
            SEL_STATUS: sel_val = count_i;
            SEL_MASK:   sel_val = mask_i;
            default:    sel_val = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)          rdata_o <= '0;
        else if (op_i.rd)   rdata_o <= sel_val;
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int STEP     = 2,
    parameter int GATE_BIT = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    output logic              irq_o
);

    bus_op_t           op;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] count_q;

    itmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .op_o    (op)
    );

    itmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .wdata_i  (wdata_i),
        .reload_o (reload_q),
        .mask_o   (mask_q)
    );

    itmr_counter #(.DATA_W(DATA_W), .STEP(STEP)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .wdata_i  (wdata_i),
        .reload_i (reload_q),
        .gate_i   (mask_q[GATE_BIT]),
        .tick_i   (tick_i),
        .count_o  (count_q),
        .irq_o    (irq_o)
    );

    itmr_rdmux #(.DATA_W(DATA_W)) u_rd (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .reload_i (reload_q),
        .mask_i   (mask_q),
        .count_i  (count_q),
        .rdata_o  (rdata_o)
    );

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int STEP   = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              tick_i,
    input logic              gate_i,
    input logic [DATA_W-1:0] reload_i,
    input logic [DATA_W-1:0] count_i,
    input logic              irq_i
);

    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
    localparam logic signed [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic idle;
    assign idle = !wr_en_i && !rd_en_i;

    // R10: bus protocol, one strobe per cycle
    assert_strobes_excl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && rd_en_i));

    assert_reload_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == A_RELOAD) |=> count_i == $past(wdata_i));

    assert_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (idle && tick_i && gate_i && $signed(reload_i) > 0 && $signed(count_i) > 0)
        |=> $signed(count_i) == $signed($past(count_i)) - STEP_V);

    assert_no_gate_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (idle && !gate_i) |=> $stable(count_i) && $stable(irq_i));

    assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_i) |-> $past(tick_i) && $signed(count_i) <= 0);

    assert_halt_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (idle && $signed(count_i) <= 0) |=> $stable(count_i));

    assert_ack_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((wr_en_i || rd_en_i) && addr_i == A_STATUS)
        |=> !irq_i && count_i == $past(reload_i));

endmodule

bind interval_timer itmr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .STEP   (STEP)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick_i),
    .gate_i   (mask_q[GATE_BIT]),
    .reload_i (reload_q),
    .count_i  (count_q),
    .irq_i    (irq_o)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .tick_i  (tick),
        .irq_o   (irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per completed read.
    always @(posedge clk) rd_seen <= rst ? 1'b0 : rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read data", rdata, 32'h0BAD_0BAD);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, logic [31:0] e, string tag, logic with_tick = 1'b0);
        @(negedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1; addr = a; tick = with_tick;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        check("R1 rdata after reset", rdata, 32'd0);
        bus_rd(2'd0, 32'd0, "R1 reload reset");
        bus_rd(2'd2, 32'd0, "R1 mask reset");
        bus_rd(2'd1, 32'd0, "R1 count reset");

        bus_wr(2'd2, 32'h2);
        bus_wr(2'd0, 32'd7);
        bus_rd(2'd0, 32'd7, "R2 reload readback");
        bus_rd(2'd2, 32'h2, "R8 mask readback");

        pulse(2);
        check("R3 irq low mid-count", {31'b0, irq}, 32'd0);
        bus_rd(2'd1, 32'd3, "R3 count after two ticks");

        pulse(3);
        check("R5 irq low at count 1", {31'b0, irq}, 32'd0);
        pulse(1);
        check("R5 irq on undershoot", {31'b0, irq}, 32'd1);
        pulse(2);
        check("R5 irq held", {31'b0, irq}, 32'd1);
        bus_rd(2'd1, 32'hFFFF_FFFF, "R5 count halted at -1");
        check("R6 irq cleared by status read", {31'b0, irq}, 32'd0);
        bus_rd(2'd1, 32'd7, "R6 count reloaded");

        bus_wr(2'd2, 32'hFFFF_FFFD);
        pulse(3);
        bus_rd(2'd2, 32'hFFFF_FFFD, "R8 mask full readback");
        bus_rd(2'd1, 32'd7, "R4 gate bit clear");

        bus_wr(2'd2, 32'h2);
        bus_wr(2'd0, 32'hFFFF_FFF0);
        pulse(2);
        check("R4 irq with negative reload", {31'b0, irq}, 32'd0);
        bus_rd(2'd1, 32'hFFFF_FFF0, "R4 negative reload holds");

        bus_wr(2'd0, 32'd4);
        pulse(2);
        check("R5 irq at exact zero", {31'b0, irq}, 32'd1);
        bus_wr(2'd1, 32'h55);
        check("R7 irq cleared by status write", {31'b0, irq}, 32'd0);
        bus_rd(2'd1, 32'd4, "R7 count equals reload");

        bus_wr(2'd0, 32'd2);
        bus_rd(2'd1, 32'd2, "R9 status read with tick", 1'b1);
        check("R9 irq stays low", {31'b0, irq}, 32'd0);
        bus_rd(2'd1, 32'd2, "R9 tick lost");

        bus_wr(2'd3, 32'hABCD);
        bus_rd(2'd3, 32'd0, "R10 unmapped reads zero");
        bus_rd(2'd0, 32'd2, "R10 unmapped write ignored");
        repeat (3) @(negedge clk);
        check("R10 rdata held", rdata, 32'd2);
        check("R10 all reads returned", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule